// File: doc/BRIEF.md
# Pulse-Width Bit Demodulator with Block Assembly

This block takes a stream of 8-bit amplitude samples from a low-frequency reader front end and recovers the bits that a tag encodes in the spacing of its signal edges. It tracks whether the signal is rising or falling. Each time that direction flips, it measures how many valid samples have passed since the previous flip. The measured interval is sorted into one of four classes: a full bit period, a half bit period, a long silence, or an error. A full-period interval yields a 1. Two half-period intervals in a row yield a 0.

Bits are collected into 128-bit blocks. A long silence closes the current block. If exactly 128 bits were gathered, the block is copied aside and sent out as 16 bytes, one per clock, each tagged with its byte index and block index. Once four blocks have been kept, the block ignores any further samples and raises a done flag after the last byte has gone out. An error counter records intervals that fit no class.

Top module: `pwdemod_top`

## Requirements
- R1: After reset, byte_valid is 0, done is 0 and err_count is 0.
- R2: An interval within 57 to 71 samples (strictly less than 8 from the 64-sample period) emits a 1 bit.
- R3: An interval within 25 to 39 samples is a half interval. The second half interval emits a 0 bit and clears the pending half. A full or error interval arriving between two halves leaves the pending half untouched.
- R4: An interval of at most 128 samples that is neither full nor half emits no bit and adds one to err_count, which saturates at 255.
- R5: The direction is falling when the previous sample is greater than the current one, and rising otherwise, so equal samples count as rising. An interval is the number of samples with smp_valid high between two direction changes. Cycles with smp_valid low do not count.
- R6: An interval longer than 128 samples ends the block. It resets the bit index and any pending half. The block is kept only when the bit index is exactly 128 at that moment.
- R7: A kept block appears as 16 bytes on consecutive cycles with byte_idx running 0 to 15. Byte j carries stream bits 8j to 8j+7, with bit 8j in the LSB. block_idx gives the order in which the block was kept (0 to 3).
- R8: Once four blocks have been kept, samples are ignored: err_count freezes and no further bytes appear. done rises after the last byte and stays high until reset.
- R9: The interval counter saturates at 255 instead of wrapping, so a silence of any length counts as a block end.
- R10: The bit index returns to 0 on reaching 255. Only bits at positions below 128 are stored, so bits that arrive after a wrap overwrite the earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 8 | Amplitude sample |
| byte_valid | output | 1 | Output byte strobe |
| byte_data | output | 8 | Output byte of a kept block |
| byte_idx | output | 4 | Byte position within the block |
| block_idx | output | 2 | Order number of the kept block |
| done | output | 1 | All four blocks delivered |
| err_count | output | 8 | Saturating count of unclassifiable intervals |

## Verification
The assertions rely on a property of the input: two kept blocks are always separated by at least 128 direction changes, so a new block can never be captured while the previous one is still streaming its 16 bytes. The stimulus is built from segments of known length. Each segment is either a flat run at a high level, which reads as rising, or a descent of one step per sample that starts just below that level, which reads as falling. Falling segments never exceed 249 samples, so every interval the bench asks for is exactly the one the design measures, including the tolerance edges and the saturated silence. Idle cycles are also inserted in one block to confirm that only valid samples are counted.

// File: rtl/pwdemod_pkg.sv
package pwdemod_pkg;

    // Default configuration
    localparam int SAMPLE_W_DEF   = 8;
    localparam int PERIOD_DEF     = 64;
    localparam int BLOCK_BITS_DEF = 128;
    localparam int NUM_BLOCKS_DEF = 4;
    localparam int IDX_WRAP_DEF   = 255;
    localparam int ERR_W_DEF      = 8;

    // Width of the event fields carried between stages
    localparam int EV_W = 16;

    typedef enum logic [1:0] {
        IV_ERROR = 2'd0,
        IV_HALF  = 2'd1,
        IV_FULL  = 2'd2,
        IV_GAP   = 2'd3
    } iv_class_e;

    // One measured interval, emitted on a direction change
    typedef struct packed {
        logic            valid;
        logic [EV_W-1:0] len;
    } edge_ev_t;

    // One decoded event: a bit, or a block end
    typedef struct packed {
        logic            bit_vld;
        logic            bit_val;
        logic [EV_W-1:0] pos;
        logic            blk_end;
        logic            blk_full;
    } bit_ev_t;

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // Sort an interval into its class; the window is strict (< period/8)
    function automatic iv_class_e classify(input int len, input int period);
        int tol;
        tol = period / 8;
        if (len > 2 * period)
            return IV_GAP;
        else if (absdiff(len, period / 2) < tol)
            return IV_HALF;
        else if (absdiff(len, period) < tol)
            return IV_FULL;
        else
            return IV_ERROR;
    endfunction

endpackage

// File: rtl/pwdemod_edge.sv
module pwdemod_edge
    import pwdemod_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int CNT_MAX  = 4 * PERIOD_DEF - 1,
    localparam int CW      = $clog2(CNT_MAX + 1)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [SAMPLE_W-1:0] in_smp,
    output edge_ev_t            ev
);

    logic [SAMPLE_W-1:0] prev_q;
    logic                primed_q;
    logic                dir_q;
    logic [CW-1:0]       cnt_q;
    logic                dir_now;
    logic                turn;

    // falling only when strictly lower than the previous sample
    assign dir_now = (prev_q > in_smp) ? 1'b0 : 1'b1;
    assign turn    = in_vld && primed_q && (dir_now != dir_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
            dir_q    <= 1'b1;
            cnt_q    <= '0;
            ev       <= '0;
        end else begin
            ev.valid <= 1'b0;
            if (in_vld) begin
                prev_q   <= in_smp;
                primed_q <= 1'b1;
                if (primed_q)
                    dir_q <= dir_now;
                if (turn) begin
                    ev.valid <= 1'b1;
                    ev.len   <= EV_W'(cnt_q);
                    cnt_q    <= CW'(1);
                end else if (cnt_q != CW'(CNT_MAX)) begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    a_r5_event_from_sample: assert property (@(posedge clk) disable iff (rst)
        ev.valid |-> $past(in_vld));

    a_r9_len_bounded: assert property (@(posedge clk) disable iff (rst)
        ev.valid |-> (ev.len != '0 && ev.len <= EV_W'(CNT_MAX)));

endmodule

// File: rtl/pwdemod_bitgen.sv
module pwdemod_bitgen
    import pwdemod_pkg::*;
#(
    parameter int PERIOD     = PERIOD_DEF,
    parameter int BLOCK_BITS = BLOCK_BITS_DEF,
    parameter int IDX_WRAP   = IDX_WRAP_DEF,
    parameter int ERR_W      = ERR_W_DEF,
    localparam int IW        = $clog2(IDX_WRAP + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  edge_ev_t         ev,
    output bit_ev_t          bo,
    output logic [ERR_W-1:0] err_cnt
);

    iv_class_e      cls;
    logic           half_q;
    logic [IW-1:0]  idx_q;
    logic [IW-1:0]  idx_inc;

    assign cls = classify(int'(ev.len), PERIOD);

    always_comb begin
        idx_inc = idx_q + IW'(1);
        if (idx_inc == IW'(IDX_WRAP))
            idx_inc = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q  <= 1'b0;
            idx_q   <= '0;
            err_cnt <= '0;
            bo      <= '0;
        end else begin
            bo.bit_vld <= 1'b0;
            bo.blk_end <= 1'b0;
            if (ev.valid) begin
                case (cls)
                    IV_GAP: begin
                        bo.blk_end  <= 1'b1;
                        bo.blk_full <= (idx_q == IW'(BLOCK_BITS));
                        idx_q       <= '0;
                        half_q      <= 1'b0;
                    end
                    IV_FULL: begin
                        bo.bit_vld <= 1'b1;
                        bo.bit_val <= 1'b1;
                        bo.pos     <= EV_W'(idx_q);
                        idx_q      <= idx_inc;
                    end
                    IV_HALF: begin
                        if (half_q) begin
                            bo.bit_vld <= 1'b1;
                            bo.bit_val <= 1'b0;
                            bo.pos     <= EV_W'(idx_q);
                            idx_q      <= idx_inc;
                            half_q     <= 1'b0;
                        end else begin
                            half_q <= 1'b1;
                        end
                    end
                    default: begin
                        if (err_cnt != '1)
                            err_cnt <= err_cnt + ERR_W'(1);
                    end
                endcase
            end
        end
    end

    a_r4_err_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + ERR_W'(1)));

    a_r3_zero_clears_half: assert property (@(posedge clk) disable iff (rst)
        (bo.bit_vld && !bo.bit_val) |-> !half_q);

    a_r6_end_clears_state: assert property (@(posedge clk) disable iff (rst)
        bo.blk_end |-> (idx_q == '0 && !half_q));

    a_r10_idx_below_wrap: assert property (@(posedge clk) disable iff (rst)
        idx_q < IW'(IDX_WRAP));

endmodule

// File: rtl/pwdemod_pack.sv
module pwdemod_pack
    import pwdemod_pkg::*;
#(
    parameter int BLOCK_BITS = BLOCK_BITS_DEF,
    parameter int NUM_BLOCKS = NUM_BLOCKS_DEF,
    localparam int NBYTES    = BLOCK_BITS / 8,
    localparam int BW        = $clog2(NBYTES),
    localparam int KW        = $clog2(NUM_BLOCKS),
    localparam int TW        = $clog2(NUM_BLOCKS + 1),
    localparam int PW        = $clog2(BLOCK_BITS)
)(
    input  logic          clk,
    input  logic          rst,
    input  bit_ev_t       bev,
    output logic          byte_valid,
    output logic [7:0]    byte_data,
    output logic [BW-1:0] byte_idx,
    output logic [KW-1:0] block_idx,
    output logic          halt,
    output logic          done
);

    logic [BLOCK_BITS-1:0] fill_q;
    logic [BLOCK_BITS-1:0] shadow_q;
    logic                  stream_q;
    logic [BW-1:0]         ptr_q;
    logic [KW-1:0]         cur_blk_q;
    logic [TW-1:0]         taken_q;
    logic                  take;

    assign take = bev.blk_end && bev.blk_full && (taken_q < TW'(NUM_BLOCKS));
    assign halt = (taken_q == TW'(NUM_BLOCKS));

    // bit collection: positions past the block size are dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else if (bev.bit_vld && bev.pos < EV_W'(BLOCK_BITS)) begin
            fill_q[bev.pos[PW-1:0]] <= bev.bit_val;
        end
    end

    // capture and byte streaming
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q  <= '0;
            stream_q  <= 1'b0;
            ptr_q     <= '0;
            cur_blk_q <= '0;
            taken_q   <= '0;
        end else if (take) begin
            shadow_q  <= fill_q;
            stream_q  <= 1'b1;
            ptr_q     <= '0;
            cur_blk_q <= taken_q[KW-1:0];
            taken_q   <= taken_q + TW'(1);
        end else if (stream_q) begin
            ptr_q <= ptr_q + BW'(1);
            if (ptr_q == BW'(NBYTES - 1))
                stream_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_valid <= 1'b0;
            byte_data  <= '0;
            byte_idx   <= '0;
            block_idx  <= '0;
            done       <= 1'b0;
        end else begin
            byte_valid <= stream_q;
            byte_data  <= shadow_q[{ptr_q, 3'b000} +: 8];
            byte_idx   <= ptr_q;
            block_idx  <= cur_blk_q;
            done       <= halt && !stream_q;
        end
    end

    a_r7_bytes_in_order: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && byte_idx != BW'(NBYTES - 1)) |=>
            (byte_valid && byte_idx == $past(byte_idx) + BW'(1)));

    a_r7_no_capture_while_streaming: assert property (@(posedge clk) disable iff (rst)
        take |-> !stream_q);

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !byte_valid);

endmodule

// File: rtl/pwdemod_top.sv
module pwdemod_top
    import pwdemod_pkg::*;
#(
    parameter int SAMPLE_W   = SAMPLE_W_DEF,
    parameter int PERIOD     = PERIOD_DEF,
    parameter int BLOCK_BITS = BLOCK_BITS_DEF,
    parameter int NUM_BLOCKS = NUM_BLOCKS_DEF,
    parameter int IDX_WRAP   = IDX_WRAP_DEF,
    parameter int ERR_W      = ERR_W_DEF,
    localparam int CNT_MAX   = 4 * PERIOD - 1,
    localparam int BW        = $clog2(BLOCK_BITS / 8),
    localparam int KW        = $clog2(NUM_BLOCKS)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                byte_valid,
    output logic [7:0]          byte_data,
    output logic [BW-1:0]       byte_idx,
    output logic [KW-1:0]       block_idx,
    output logic                done,
    output logic [ERR_W-1:0]    err_count
);

    edge_ev_t ev;
    bit_ev_t  bev;
    logic     halt;
    logic     gated_vld;

    // stop collecting once every block slot has been filled
    assign gated_vld = smp_valid && !halt;

    pwdemod_edge #(
        .SAMPLE_W (SAMPLE_W),
        .CNT_MAX  (CNT_MAX)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .in_vld (gated_vld),
        .in_smp (smp_data),
        .ev     (ev)
    );

    pwdemod_bitgen #(
        .PERIOD     (PERIOD),
        .BLOCK_BITS (BLOCK_BITS),
        .IDX_WRAP   (IDX_WRAP),
        .ERR_W      (ERR_W)
    ) u_bitgen (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .bo      (bev),
        .err_cnt (err_count)
    );

    pwdemod_pack #(
        .BLOCK_BITS (BLOCK_BITS),
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_pack (
        .clk        (clk),
        .rst        (rst),
        .bev        (bev),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_idx   (byte_idx),
        .block_idx  (block_idx),
        .halt       (halt),
        .done       (done)
    );

endmodule

// File: tb/sim_pwdemod_top.sv
module sim_pwdemod_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = 8'd0;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic [3:0] byte_idx;
    logic [1:0] block_idx;
    logic       done;
    logic [7:0] err_count;

    always #10 clk = ~clk;

    pwdemod_top u0 (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_idx   (byte_idx),
        .block_idx  (block_idx),
        .done       (done),
        .err_count  (err_count)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // received bytes
    int         rx_n = 0;
    logic [7:0] rx_byte [64];
    logic [3:0] rx_bi   [64];
    logic [1:0] rx_bk   [64];

    always @(negedge clk) begin
        if (!rst && byte_valid) begin
            if (rx_n < 64) begin
                rx_byte[rx_n] = byte_data;
                rx_bi[rx_n]   = byte_idx;
                rx_bk[rx_n]   = block_idx;
            end
            rx_n++;
        end
    end

    // model state
    logic exp_bits [512];
    logic mbuf [128];
    int   midx = 0;
    int   mblocks = 0;
    int   merr = 0;
    bit   next_up = 1'b1;
    int   level = 250;
    bit   gap_mode = 1'b0;
    int   gap_ctr = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] v);
        if (gap_mode) begin
            gap_ctr++;
            if (gap_ctr % 4 == 0) begin
                @(negedge clk);
                smp_valid = 1'b0;
            end
        end
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = v;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            smp_valid = 1'b0;
        end
    endtask

    // one segment of L samples in one direction
    task automatic send_iv(input int len);
        if (next_up) begin
            for (int k = 0; k < len; k++) put(8'd250);
            level = 250;
        end else begin
            for (int k = 0; k < len; k++) begin
                level--;
                put(8'(level));
            end
        end
        next_up = !next_up;
    endtask

    task automatic m_bit(input bit b);
        if (mblocks < 4) begin
            if (midx < 128) mbuf[midx] = b;
            midx++;
            if (midx == 255) midx = 0;
        end
    endtask

    task automatic send_bit(input bit b, input int v);
        if (b) begin
            send_iv(57 + v % 15);
        end else begin
            send_iv(25 + v % 15);
            send_iv(25 + (v + 7) % 15);
        end
        m_bit(b);
    endtask

    task automatic send_err(input int len);
        send_iv(len);
        if (mblocks < 4 && merr < 255) merr++;
    endtask

    task automatic send_gap(input int len);
        send_iv(len);
        if (mblocks < 4) begin
            if (midx == 128) begin
                for (int k = 0; k < 128; k++) exp_bits[mblocks * 128 + k] = mbuf[k];
                mblocks++;
            end
            midx = 0;
        end
    endtask

    function automatic bit pat(input int b, input int i);
        return ((((i * 5 + b * 7) % 3) == 0) ^ (((i >> 3) & 1) == 1));
    endfunction

    task automatic check_bytes(input int from, input int to, input string req);
        for (int k = from; k < to; k++) begin
            logic [7:0] e;
            for (int q = 0; q < 8; q++) e[q] = exp_bits[(k / 16) * 128 + (k % 16) * 8 + q];
            check(rx_byte[k] == e, req, int'(rx_byte[k]), int'(e));
            check(rx_bi[k] == 4'(k % 16) && rx_bk[k] == 2'(k / 16), "R7 order",
                  int'({rx_bk[k], rx_bi[k]}), ((k / 16) << 4) | (k % 16));
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int segs;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(byte_valid == 1'b0, "R1 byte_valid", int'(byte_valid), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(err_count == 8'd0, "R1 err_count", int'(err_count), 0);

        // lead-in, then tolerance edges: all errors (R4)
        send_gap(200);
        send_err(56);
        send_err(72);
        send_err(24);
        send_err(40);
        send_err(128);
        send_gap(200);
        send_gap(200);
        check(err_count == 8'(merr), "R4 errors at window edges", int'(err_count), merr);
        check(rx_n == 0, "R6 empty block dropped", rx_n, 0);

        // block 0: edges 57/71 and 25/39 inside the mix (R2, R3)
        for (int i = 0; i < 128; i++) send_bit(pat(0, i), i);
        send_gap(200);
        send_gap(200);
        check(rx_n == 16, "R6 full block kept", rx_n, 16);
        check_bytes(0, 16, "R2 R3 R7 block0 byte");
        check(err_count == 8'(merr), "R4 no errors from good bits", int'(err_count), merr);

        // short block with a pending half, then a block with idle gaps (R5, R6, R3)
        for (int i = 0; i < 100; i++) send_bit(pat(1, i), i + 3);
        send_iv(32);
        send_gap(200);
        gap_mode = 1'b1;
        send_iv(30);
        send_bit(1'b1, 4);
        send_iv(36);
        m_bit(1'b0);
        send_iv(28);
        send_err(50);
        send_iv(38);
        m_bit(1'b0);
        for (int i = 0; i < 125; i++) send_bit(pat(1, i), i);
        send_gap(200);
        gap_mode = 1'b0;
        send_gap(200);
        check(rx_n == 32, "R6 short block dropped", rx_n, 32);
        check_bytes(16, 32, "R3 R5 block1 byte");
        check(err_count == 8'(merr), "R4 error between halves", int'(err_count), merr);

        // wrap of the bit index (R10)
        for (int i = 0; i < 383; i++) send_bit(pat(2, i), i);
        send_gap(200);
        send_gap(200);
        check(rx_n == 48, "R10 block after wrap", rx_n, 48);
        check_bytes(32, 48, "R10 block2 byte");

        // last block closed by a saturated silence (R9)
        segs = 0;
        for (int i = 0; i < 128; i++) segs += pat(3, i) ? 1 : 2;
        if ((next_up ^ segs[0]) != 1'b1) send_gap(200);
        for (int i = 0; i < 128; i++) send_bit(pat(3, i), i + 1);
        send_gap(300);
        send_iv(20);
        idle(40);
        check(rx_n == 64, "R9 long silence ends block", rx_n, 64);
        check_bytes(48, 64, "R9 block3 byte");
        check(done == 1'b1, "R8 done after four blocks", int'(done), 1);

        // everything after done is ignored (R8)
        send_err(50);
        send_err(90);
        for (int i = 0; i < 130; i++) send_bit(pat(0, i), i);
        send_gap(200);
        send_gap(200);
        idle(40);
        check(err_count == 8'(merr), "R8 errors frozen", int'(err_count), merr);
        check(rx_n == 64, "R8 no more bytes", rx_n, 64);
        check(done == 1'b1, "R8 done holds", int'(done), 1);
        summary();
    end

endmodule